// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming network frames into a circular receive area of shared memory. The area is cut into 256-byte pages and runs from a first page up to, but not including, a limit page. For each frame it writes the payload bytes from the fifth byte of the current page onward, wrapping from the end of the area back to its first page. When the frame ends it writes a 4-byte header at the start of the frame's first page and moves the current-page pointer to the page that follows the frame.

The host reads frames out by following the next-page links in the headers. It keeps a boundary register one page behind the next frame it has not yet read. A frame that would enter the boundary page, or leave the current pointer on it, is discarded. The current pointer then stays where it was, a sticky overwrite-warning flag is raised, and frames already stored are kept. A good frame raises a frame-intact flag, which is also copied into bit 0 of the header status byte. The MAC receive path, CRC checking and the host's copy-out are outside the block.

The receive side presents a frame as a one-cycle start strobe, one byte per cycle with a valid strobe, and a one-cycle end strobe that carries the good/bad verdict. The end strobe carries no byte.

Top module: `rx_page_ring`

## Requirements
- R1: Reset is synchronous and active low. Out of reset the current page equals the reset first page, the boundary equals the reset limit page minus one, both flags are low and the empty indicator is high.
- R2: A byte accepted during a frame appears on the memory write port one cycle later. The address is the page number in bits 15:8 and the offset in bits 7:0. The frame's first byte goes to offset 4 of the current page and the following bytes go to consecutive offsets.
- R3: A frame overflows when its byte pointer moves into the boundary page, or when its next page equals the boundary at the end of a good frame. On overflow the rest of the frame is dropped, no header is written and the current page is unchanged. The overwrite flag is set and stays set until the clear input is pulsed.
- R4: A committed frame's header is written one cycle after the end strobe, as one 32-bit word at offset 0 of the frame's first page. Bits 7:0 hold the status (bit 0 = intact, other bits 0), bits 15:8 hold the next page, and bits 31:16 hold the length (low byte at bits 23:16).
- R5: The header length equals the number of bytes accepted for the frame, frame check sequence included.
- R6: The next page is the page after the last page the frame wrote, wrapping from the limit page to the first page. A frame that ends exactly at a page end links to the page just entered. The current page takes this value one cycle after the end strobe.
- R7: Within a frame, the byte after offset 255 of page limit-1 goes to offset 0 of the first page. No memory write falls outside the pages from first to limit-1.
- R8: The empty indicator is high exactly when the current page equals the boundary plus one, with wrap.
- R9: A good committed frame sets the intact flag. A frame ended with a bad verdict writes no header, leaves the current page unchanged and clears the intact flag. An overflow also clears the intact flag.
- R10: Configuration writes select the target with cfg_sel: 0 = first page, 1 = limit page, 2 = current page, 3 = boundary. A boundary write takes effect at the next clock edge. A write to the first, limit or current page while a frame is active is held, and takes effect on the first clock edge after the frame ends. The same write when no frame is active takes effect at the next edge.
- R11: A valid byte presented while no frame is active is ignored and produces no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target (0 first, 1 limit, 2 current, 3 boundary) |
| cfg_wdata | input | PAGE_W | Page value to write |
| ovw_clr | input | 1 | Clears the overwrite flag |
| rx_sof | input | 1 | Frame start strobe (no data) |
| rx_valid | input | 1 | Payload byte valid |
| rx_data | input | 8 | Payload byte |
| rx_eof | input | 1 | Frame end strobe (no data) |
| rx_good | input | 1 | Verdict sampled with rx_eof, 1 = good |
| mem_we | output | 1 | Payload byte write strobe |
| mem_addr | output | ADDR_W | Payload byte address |
| mem_wdata | output | 8 | Payload byte |
| hdr_we | output | 1 | Header word write strobe |
| hdr_addr | output | ADDR_W | Header address (offset 0 of the frame's first page) |
| hdr_data | output | 16+PAGE_W+8 | Header word: length, next page, status |
| cur_page | output | PAGE_W | Current page pointer |
| bnd_page | output | PAGE_W | Boundary page |
| ring_empty | output | 1 | Current equals boundary plus one |
| ovw_flag | output | 1 | Sticky overwrite warning |
| prx_flag | output | 1 | Last frame stored intact |

## Verification
The hardest situations to reach from the ports are the two overflow cases: a frame that runs into the boundary page mid-stream, and a frame that fits but whose next page lands exactly on the boundary. Both need a specific gap between the current page and the boundary. The bench shrinks the ring to four pages and chooses frame lengths that cross the boundary at a page edge, or that end partway into the page just before it. A staged pointer write issued in the middle of a frame is also placed directly, and the bench checks the link value and the staged value on consecutive cycles. A random phase then mixes lengths up to 700 bytes, bad verdicts and irregular host consumption. Its expected pointers and overflows come from a page-walk model in the bench, and stored frames are read back through their headers.

// File: rtl/rxr_pkg.sv
// Package: shared constants and types for the paged receive ring manager.
// Assumes pages are 256 bytes, so an in-page offset is always 8 bits wide.
package rxr_pkg;

    // Configuration targets; the values are the cfg_sel encoding.
    typedef enum logic [1:0] {
        SEL_FIRST = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_BOUND = 2'd3
    } cfg_sel_e;

    localparam int OFF_W      = 8;   // offset bits inside one page
    localparam int LEN_W      = 16;  // length field of the header
    localparam int HDR_BYTES  = 4;   // header size at the start of a frame
    localparam int STATUS_W   = 8;   // status byte of the header
    localparam int INTACT_BIT = 0;   // status bit meaning the frame is good

endpackage

// File: rtl/rxr_cfg_regs.sv
// Module: rxr_cfg_regs
// Holds the first, limit, current and boundary page registers.
// Writes to first/limit/current made while a frame is active are parked
// and applied on the first edge with no frame active; the boundary is
// written at once. The current page also takes the commit value from
// the frame writer. Assumes commit_we is only ever high while busy.
module rxr_cfg_regs #(
    parameter int                  PAGE_W    = 8,
    parameter logic [PAGE_W-1:0]   RST_FIRST = 8'h40,
    parameter logic [PAGE_W-1:0]   RST_LIMIT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PAGE_W-1:0] cfg_wdata,
    input  logic              busy,
    input  logic              commit_we,
    input  logic [PAGE_W-1:0] commit_page,
    output logic [PAGE_W-1:0] first_pg,
    output logic [PAGE_W-1:0] limit_pg,
    output logic [PAGE_W-1:0] cur_pg,
    output logic [PAGE_W-1:0] hold_pg,
    output logic [PAGE_W-1:0] eff_cur
);
    import rxr_pkg::*;

    localparam int NSTAGED = 3;
    localparam logic [PAGE_W-1:0] ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

    logic [PAGE_W-1:0] stage_val [NSTAGED];
    logic [PAGE_W-1:0] stage_eff [NSTAGED];

    for (genvar i = 0; i < NSTAGED; i++) begin : g_staged
        localparam logic [PAGE_W-1:0] RV = (i == 1) ? RST_LIMIT : RST_FIRST;
        logic              hit;
        logic [PAGE_W-1:0] val_q;
        logic [PAGE_W-1:0] park_q;
        logic              park_v;

        assign hit = cfg_we && (cfg_sel == 2'(i));

        // Register update: commit, direct write when idle, or parked value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= RV;
                park_q <= '0;
                park_v <= 1'b0;
            end else begin
                if ((i == 2) && commit_we)
                    val_q <= commit_page;
                else if (!busy && hit)
                    val_q <= cfg_wdata;
                else if (!busy && park_v)
                    val_q <= park_q;
                if (busy && hit) begin
                    park_q <= cfg_wdata;
                    park_v <= 1'b1;
                end else if (!busy) begin
                    park_v <= 1'b0;
                end
            end
        end

        // Value the register will hold after this edge when idle.
        always_comb begin
            if (!busy && hit)
                stage_eff[i] = cfg_wdata;
            else if (!busy && park_v)
                stage_eff[i] = park_q;
            else
                stage_eff[i] = val_q;
        end

        assign stage_val[i] = val_q;
    end

    // Boundary register: host-owned, written immediately.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_pg <= RST_LIMIT - ONE;
        else if (cfg_we && cfg_sel == SEL_BOUND)
            hold_pg <= cfg_wdata;
    end

    assign first_pg = stage_val[SEL_FIRST];
    assign limit_pg = stage_val[SEL_LIMIT];
    assign cur_pg   = stage_val[SEL_CUR];
    assign eff_cur  = stage_eff[SEL_CUR];

endmodule

// File: rtl/rxr_frame_writer.sv
// Module: rxr_frame_writer
// Walks the byte pointer through the ring for one frame at a time,
// issues the payload writes, counts the length, and decides at the end
// whether the frame commits, is rejected, or overflowed the boundary.
// Assumes rx_sof and rx_eof carry no byte; rx_sof has top priority.
module rxr_frame_writer #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_sof,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 rx_eof,
    input  logic                 rx_good,
    input  logic [PAGE_W-1:0]    first_pg,
    input  logic [PAGE_W-1:0]    limit_pg,
    input  logic [PAGE_W-1:0]    start_pg,
    input  logic [PAGE_W-1:0]    hold_pg,
    output logic                 busy,
    output logic                 mem_we,
    output logic [PAGE_W+7:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    output logic                 commit_we,
    output logic [PAGE_W-1:0]    next_pg,
    output logic [LEN_W-1:0]     frame_len,
    output logic                 ovf_evt,
    output logic                 bad_evt
);
    import rxr_pkg::*;

    localparam logic [PAGE_W-1:0] ONE    = {{(PAGE_W-1){1'b0}}, 1'b1};
    localparam logic [OFF_W-1:0]  OFF0   = OFF_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0]  OFFEND = '1;

    logic              active_q;
    logic [PAGE_W-1:0] wr_page_q;
    logic [OFF_W-1:0]  wr_off_q;
    logic [LEN_W-1:0]  len_q;
    logic [PAGE_W-1:0] step_pg;
    logic              byte_acc;
    logic              page_cross;
    logic              cross_ovf;
    logic              end_evt;
    logic              end_ovf;

    // Page increment with wrap from limit back to first.
    function automatic logic [PAGE_W-1:0] pg_step(
        input logic [PAGE_W-1:0] p,
        input logic [PAGE_W-1:0] lo,
        input logic [PAGE_W-1:0] hi
    );
        logic [PAGE_W-1:0] q;
        q = p + ONE;
        return (q >= hi || q == '0) ? lo : q;
    endfunction

    // Decode of this cycle's events on the frame input.
    always_comb begin
        step_pg    = pg_step(wr_page_q, first_pg, limit_pg);
        byte_acc   = active_q && rx_valid && !rx_sof && !rx_eof;
        page_cross = byte_acc && (wr_off_q == OFFEND);
        cross_ovf  = page_cross && (step_pg == hold_pg);
        end_evt    = active_q && rx_eof && !rx_sof;
        next_pg    = (wr_off_q == '0) ? wr_page_q : step_pg;
        end_ovf    = end_evt && rx_good && (next_pg == hold_pg);
        commit_we  = end_evt && rx_good && !end_ovf;
        bad_evt    = end_evt && !rx_good;
        ovf_evt    = cross_ovf || end_ovf;
    end

    // Frame pointer, length and activity tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            wr_page_q <= '0;
            wr_off_q  <= '0;
            len_q     <= '0;
        end else if (rx_sof) begin
            active_q  <= 1'b1;
            wr_page_q <= start_pg;
            wr_off_q  <= OFF0;
            len_q     <= '0;
        end else if (end_evt || cross_ovf) begin
            active_q  <= 1'b0;
        end else if (byte_acc) begin
            len_q    <= len_q + LEN_W'(1);
            wr_off_q <= wr_off_q + OFF_W'(1);
            if (page_cross)
                wr_page_q <= step_pg;
        end
    end

    // Registered payload write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= byte_acc;
            if (byte_acc) begin
                mem_addr  <= {wr_page_q, wr_off_q};
                mem_wdata <= rx_data;
            end
        end
    end

    assign busy      = active_q;
    assign frame_len = len_q;

endmodule

// File: rtl/rxr_commit_status.sv
// Module: rxr_commit_status
// Builds the 4-byte frame header on commit and keeps the sticky
// overwrite flag and the frame-intact flag.
// Assumes commit, bad and overflow events are mutually exclusive.
module rxr_commit_status #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_we,
    input  logic                        bad_evt,
    input  logic                        ovf_evt,
    input  logic                        ovw_clr,
    input  logic [PAGE_W-1:0]           frame_pg,
    input  logic [PAGE_W-1:0]           next_pg,
    input  logic [LEN_W-1:0]            frame_len,
    output logic                        hdr_we,
    output logic [PAGE_W+7:0]           hdr_addr,
    output logic [LEN_W+PAGE_W+7:0]     hdr_data,
    output logic                        ovw_flag,
    output logic                        prx_flag
);
    import rxr_pkg::*;

    logic [STATUS_W-1:0] status_b;

    // Status byte of a committed frame.
    always_comb begin
        status_b             = '0;
        status_b[INTACT_BIT] = 1'b1;
    end

    // Registered header write one cycle after commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_we   <= 1'b0;
            hdr_addr <= '0;
            hdr_data <= '0;
        end else begin
            hdr_we <= commit_we;
            if (commit_we) begin
                hdr_addr <= {frame_pg, 8'h00};
                hdr_data <= {frame_len, next_pg, status_b};
            end
        end
    end

    // Sticky overwrite warning; a new overflow wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovw_flag <= 1'b0;
        else if (ovf_evt)
            ovw_flag <= 1'b1;
        else if (ovw_clr)
            ovw_flag <= 1'b0;
    end

    // Frame-intact flag follows the outcome of the latest frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prx_flag <= 1'b0;
        else if (commit_we)
            prx_flag <= 1'b1;
        else if (bad_evt || ovf_evt)
            prx_flag <= 1'b0;
    end

endmodule

// File: rtl/rx_page_ring.sv
// Module: rx_page_ring (top)
// Paged receive ring manager: stores frames into a ring of 256-byte
// pages, writes a linking header per frame, and guards the host's
// boundary page. Assumes the host keeps first < limit and keeps the
// current and boundary pages inside the ring.
module rx_page_ring #(
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-9:0]  RST_FIRST = 8'h40,
    parameter logic [ADDR_W-9:0]  RST_LIMIT = 8'h80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [ADDR_W-9:0]      cfg_wdata,
    input  logic                   ovw_clr,
    input  logic                   rx_sof,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    input  logic                   rx_eof,
    input  logic                   rx_good,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    output logic                   hdr_we,
    output logic [ADDR_W-1:0]      hdr_addr,
    output logic [ADDR_W+15:0]     hdr_data,
    output logic [ADDR_W-9:0]      cur_page,
    output logic [ADDR_W-9:0]      bnd_page,
    output logic                   ring_empty,
    output logic                   ovw_flag,
    output logic                   prx_flag
);
    import rxr_pkg::*;

    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [PAGE_W-1:0] ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

    logic [PAGE_W-1:0] first_pg;
    logic [PAGE_W-1:0] limit_pg;
    logic [PAGE_W-1:0] hold_pg;
    logic [PAGE_W-1:0] eff_cur;
    logic [PAGE_W-1:0] next_pg;
    logic [LEN_W-1:0]  frame_len;
    logic              busy;
    logic              commit_we;
    logic              ovf_evt;
    logic              bad_evt;
    logic [PAGE_W-1:0] bnd_step;

    rxr_cfg_regs #(
        .PAGE_W    (PAGE_W),
        .RST_FIRST (RST_FIRST),
        .RST_LIMIT (RST_LIMIT)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .busy        (busy),
        .commit_we   (commit_we),
        .commit_page (next_pg),
        .first_pg    (first_pg),
        .limit_pg    (limit_pg),
        .cur_pg      (cur_page),
        .hold_pg     (hold_pg),
        .eff_cur     (eff_cur)
    );

    rxr_frame_writer #(
        .PAGE_W (PAGE_W),
        .LEN_W  (LEN_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_sof    (rx_sof),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eof    (rx_eof),
        .rx_good   (rx_good),
        .first_pg  (first_pg),
        .limit_pg  (limit_pg),
        .start_pg  (eff_cur),
        .hold_pg   (hold_pg),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .commit_we (commit_we),
        .next_pg   (next_pg),
        .frame_len (frame_len),
        .ovf_evt   (ovf_evt),
        .bad_evt   (bad_evt)
    );

    rxr_commit_status #(
        .PAGE_W (PAGE_W),
        .LEN_W  (LEN_W)
    ) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_we (commit_we),
        .bad_evt   (bad_evt),
        .ovf_evt   (ovf_evt),
        .ovw_clr   (ovw_clr),
        .frame_pg  (cur_page),
        .next_pg   (next_pg),
        .frame_len (frame_len),
        .hdr_we    (hdr_we),
        .hdr_addr  (hdr_addr),
        .hdr_data  (hdr_data),
        .ovw_flag  (ovw_flag),
        .prx_flag  (prx_flag)
    );

    // Empty test: current sits one page past the boundary, with wrap.
    always_comb begin
        bnd_step = hold_pg + ONE;
        if (bnd_step >= limit_pg || bnd_step == '0)
            bnd_step = first_pg;
        ring_empty = (cur_page == bnd_step);
    end

    assign bnd_page = hold_pg;

endmodule

// File: rtl/rx_page_ring_chk.sv
// Module: rx_page_ring_chk
// Property checker for rx_page_ring, bound into every instance.
module rx_page_ring_chk #(
    parameter int ADDR_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mem_we,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 hdr_we,
    input logic [ADDR_W-1:0]    hdr_addr,
    input logic [ADDR_W+15:0]   hdr_data,
    input logic [ADDR_W-9:0]    cur_page,
    input logic [ADDR_W-9:0]    bnd_page,
    input logic [ADDR_W-9:0]    first_pg,
    input logic [ADDR_W-9:0]    limit_pg,
    input logic                 ovw_flag,
    input logic                 prx_flag
);
    localparam int PAGE_W = ADDR_W - 8;

    // R7: payload writes stay inside the ring.
    p_mem_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:8] >= first_pg && mem_addr[ADDR_W-1:8] < limit_pg));

    // R4: header lands at offset 0 of the page current before commit.
    p_hdr_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we |-> (hdr_addr[7:0] == 8'h00 && hdr_addr[ADDR_W-1:8] == $past(cur_page)));

    // R6: the link field equals the new current page.
    p_hdr_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we |-> hdr_data[PAGE_W+7:8] == cur_page);

    // R3: a committed frame never links onto the boundary page.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we |-> hdr_data[PAGE_W+7:8] != $past(bnd_page));

    // R3: raising the warning leaves the current page where it was.
    p_ovw_keeps_cur_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovw_flag) |-> cur_page == $past(cur_page));

    // R9: every header reports intact and raises the intact flag.
    p_intact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we |-> (hdr_data[0] && prx_flag));

endmodule

bind rx_page_ring rx_page_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .hdr_we   (hdr_we),
    .hdr_addr (hdr_addr),
    .hdr_data (hdr_data),
    .cur_page (cur_page),
    .bnd_page (bnd_page),
    .first_pg (first_pg),
    .limit_pg (limit_pg),
    .ovw_flag (ovw_flag),
    .prx_flag (prx_flag)
);

// File: tb/rx_page_ring_test.sv
// Bench for rx_page_ring: directed corner cases then seeded random frames.
module rx_page_ring_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        ovw_clr = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        rx_eof = 1'b0;
    logic        rx_good = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        hdr_we;
    logic [15:0] hdr_addr;
    logic [31:0] hdr_data;
    logic [7:0]  cur_page;
    logic [7:0]  bnd_page;
    logic        ring_empty;
    logic        ovw_flag;
    logic        prx_flag;

    int checks = 0;
    int errors = 0;
    int mem_cnt = 0;
    int hdr_cnt = 0;
    bit done = 0;
    logic [7:0] shadow [int];
    int tb_first = 8'h40;
    int tb_limit = 8'h80;

    always #10 clk = ~clk;   // 50 MHz

    rx_page_ring uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ovw_clr(ovw_clr), .rx_sof(rx_sof),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
        .rx_good(rx_good), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .hdr_we(hdr_we), .hdr_addr(hdr_addr),
        .hdr_data(hdr_data), .cur_page(cur_page), .bnd_page(bnd_page),
        .ring_empty(ring_empty), .ovw_flag(ovw_flag), .prx_flag(prx_flag)
    );

    // Shadow memory fed from both write ports.
    always @(negedge clk) begin
        if (mem_we) begin
            shadow[int'(mem_addr)] = mem_wdata;
            mem_cnt++;
        end
        if (hdr_we) begin
            for (int k = 0; k < 4; k++)
                shadow[int'(hdr_addr) + k] = hdr_data[8*k +: 8];
            hdr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int inc_pg(input int p);
        return (p + 1 >= tb_limit) ? tb_first : p + 1;
    endfunction

    function automatic int dec_pg(input int p);
        return (p == tb_first) ? tb_limit - 1 : p - 1;
    endfunction

    function automatic logic [7:0] dat(input int tag, input int i);
        return 8'((tag * 37) + (i * 11) + (i >> 8));
    endfunction

    // Page walk of a frame: next page and the two overflow cases.
    task automatic predict(input int p0, input int bnd, input int n,
                           output int nxt, output bit mid, output bit endov);
        int p = p0;
        int off = 4;
        mid = 0;
        for (int i = 0; i < n; i++) begin
            off++;
            if (off == 256) begin
                off = 0;
                p = inc_pg(p);
                if (p == bnd) begin
                    mid = 1;
                    break;
                end
            end
        end
        nxt = (off == 0) ? p : inc_pg(p);
        endov = !mid && (nxt == bnd);
    endtask

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic pulse_clr();
        @(negedge clk); ovw_clr = 1'b1;
        @(negedge clk); ovw_clr = 1'b0;
        #1;
    endtask

    // One frame; optional configuration write alongside byte mid_idx.
    task automatic send_frame(input int n, input bit good, input int tag,
                              input int mid_idx, input int mid_sel, input int mid_val);
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data = dat(tag, i);
            if (i == mid_idx) begin
                cfg_we = 1'b1; cfg_sel = 2'(mid_sel); cfg_wdata = 8'(mid_val);
            end
            @(negedge clk);
            cfg_we = 1'b0;
        end
        rx_valid = 1'b0; rx_eof = 1'b1; rx_good = good;
        @(negedge clk);
        rx_eof = 1'b0; rx_good = 1'b0;
        #1;
    endtask

    // Read a stored frame back through its header and compare.
    task automatic verify_frame(input int tag, input int n, input int p0, input int nxt);
        int base = p0 << 8;
        int bad = 0;
        int p = p0;
        int off = 4;
        chk(shadow.exists(base) && shadow[base] == 8'h01, "R4 status byte",
            shadow.exists(base) ? int'(shadow[base]) : -1, 1);
        chk(shadow.exists(base + 1) && int'(shadow[base + 1]) == nxt, "R6 next page",
            shadow.exists(base + 1) ? int'(shadow[base + 1]) : -1, nxt);
        chk(shadow.exists(base + 3) && int'({shadow[base + 3], shadow[base + 2]}) == n,
            "R5 length", shadow.exists(base + 3) ? int'({shadow[base + 3], shadow[base + 2]}) : -1, n);
        for (int i = 0; i < n; i++) begin
            int a = (p << 8) | off;
            if (!shadow.exists(a) || shadow[a] != dat(tag, i)) bad++;
            off++;
            if (off == 256) begin
                off = 0;
                p = inc_pg(p);
            end
        end
        chk(bad == 0, "R2/R7 payload placement", bad, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int nxt;
        bit mid;
        bit endov;
        int m0;
        int h0;
        int exp_cur;
        int tb_bnd;
        int seedv;
        seedv = $urandom(32'd20240611);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        chk(cur_page == 8'h40, "R1 cur_page", cur_page, 8'h40);
        chk(bnd_page == 8'h7F, "R1 bnd_page", bnd_page, 8'h7F);
        chk(!ovw_flag && !prx_flag, "R1 flags", {ovw_flag, prx_flag}, 0);
        chk(ring_empty, "R1/R8 empty after reset", ring_empty, 1);

        // R2 R4 R5 R6: short single-page frame
        m0 = mem_cnt; h0 = hdr_cnt;
        send_frame(60, 1, 1, -1, 0, 0);
        chk(mem_cnt - m0 == 60, "R2 write count", mem_cnt - m0, 60);
        chk(hdr_cnt - h0 == 1, "R4 header written", hdr_cnt - h0, 1);
        chk(cur_page == 8'h41, "R6 cur after frame", cur_page, 8'h41);
        chk(prx_flag, "R9 intact flag", prx_flag, 1);
        chk(!ring_empty, "R8 not empty", ring_empty, 0);
        verify_frame(1, 60, 8'h40, 8'h41);

        // R11: bytes with no frame active are ignored
        m0 = mem_cnt;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            rx_valid = 1'b1; rx_data = 8'hA5;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        @(negedge clk); #1;
        chk(mem_cnt == m0, "R11 stray bytes written", mem_cnt - m0, 0);
        chk(cur_page == 8'h41, "R11 cur unchanged", cur_page, 8'h41);

        // R10 boundary write takes effect at once, R8 empty returns
        cfg_write(3, 8'h40);
        chk(bnd_page == 8'h40, "R10 boundary write", bnd_page, 8'h40);
        chk(ring_empty, "R8 empty after consume", ring_empty, 1);

        // R6: multi-page frame 600 bytes from 0x41 -> next 0x44
        send_frame(600, 1, 2, -1, 0, 0);
        chk(cur_page == 8'h44, "R6 multi-page next", cur_page, 8'h44);
        verify_frame(2, 600, 8'h41, 8'h44);

        // R7: frame wrapping from page 0x7F to 0x40
        cfg_write(2, 8'h7F);
        chk(cur_page == 8'h7F, "R10 idle cur write", cur_page, 8'h7F);
        cfg_write(3, 8'h7E);
        send_frame(300, 1, 3, -1, 0, 0);
        chk(cur_page == 8'h41, "R7 wrap next page", cur_page, 8'h41);
        verify_frame(3, 300, 8'h7F, 8'h41);

        // R9: bad frame discarded
        h0 = hdr_cnt;
        send_frame(80, 0, 4, -1, 0, 0);
        chk(cur_page == 8'h41, "R9 bad frame cur", cur_page, 8'h41);
        chk(hdr_cnt == h0, "R9 bad frame header", hdr_cnt - h0, 0);
        chk(!prx_flag, "R9 intact cleared", prx_flag, 1'b0);

        // R3: small ring 0x10..0x13, mid-frame overflow entering 0x13
        tb_first = 8'h10; tb_limit = 8'h14;
        cfg_write(0, 8'h10);
        cfg_write(1, 8'h14);
        cfg_write(2, 8'h10);
        cfg_write(3, 8'h13);
        m0 = mem_cnt; h0 = hdr_cnt;
        send_frame(900, 1, 5, -1, 0, 0);
        chk(ovw_flag, "R3 overflow flag", ovw_flag, 1);
        chk(cur_page == 8'h10, "R3 cur kept", cur_page, 8'h10);
        chk(hdr_cnt == h0, "R3 no header", hdr_cnt - h0, 0);
        chk(mem_cnt - m0 == 764, "R3 rest dropped", mem_cnt - m0, 764);
        chk(!prx_flag, "R9 intact cleared by overflow", prx_flag, 0);

        // R3: flag sticky across a good frame, then cleared
        send_frame(20, 1, 6, -1, 0, 0);
        chk(cur_page == 8'h11, "R6 small ring frame", cur_page, 8'h11);
        chk(ovw_flag, "R3 flag sticky", ovw_flag, 1);
        pulse_clr();
        chk(!ovw_flag, "R3 flag cleared", ovw_flag, 0);

        // R3: end-of-frame overflow, next page would equal boundary 0x13
        h0 = hdr_cnt;
        send_frame(300, 1, 7, -1, 0, 0);
        chk(ovw_flag, "R3 end overflow flag", ovw_flag, 1);
        chk(cur_page == 8'h11, "R3 end overflow cur", cur_page, 8'h11);
        chk(hdr_cnt == h0, "R3 end overflow header", hdr_cnt - h0, 0);
        pulse_clr();

        // R10: cur written mid-frame applies one edge after the commit
        cfg_write(3, 8'h10);
        rx_sof = 1'b0;
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        for (int i = 0; i < 40; i++) begin
            rx_valid = 1'b1; rx_data = dat(8, i);
            if (i == 10) begin
                cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h13;
            end
            @(negedge clk);
            cfg_we = 1'b0;
        end
        rx_valid = 1'b0; rx_eof = 1'b1; rx_good = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0; rx_good = 1'b0;
        #1;
        chk(cur_page == 8'h12, "R10 commit before staged", cur_page, 8'h12);
        @(negedge clk); #1;
        chk(cur_page == 8'h13, "R10 staged cur applied", cur_page, 8'h13);
        verify_frame(8, 40, 8'h11, 8'h12);

        // Random phase on the full ring
        tb_first = 8'h40; tb_limit = 8'h80;
        cfg_write(0, 8'h40);
        cfg_write(1, 8'h80);
        cfg_write(2, 8'h40);
        cfg_write(3, 8'h7F);
        pulse_clr();
        exp_cur = 8'h40; tb_bnd = 8'h7F;
        for (int f = 0; f < 40; f++) begin
            int n = 1 + int'($urandom % 700);
            bit good = ($urandom % 10) != 0;
            bit commit;
            predict(exp_cur, tb_bnd, n, nxt, mid, endov);
            commit = good && !mid && !endov;
            h0 = hdr_cnt;
            send_frame(n, good, 100 + f, -1, 0, 0);
            chk(ovw_flag == (mid || (good && endov)), "R3 random overflow", ovw_flag,
                int'(mid || (good && endov)));
            chk(prx_flag == commit, "R9 random intact", prx_flag, int'(commit));
            if (commit) begin
                chk(int'(cur_page) == nxt, "R6 random next", cur_page, nxt);
                verify_frame(100 + f, n, exp_cur, nxt);
                exp_cur = nxt;
            end else begin
                chk(int'(cur_page) == exp_cur, "R3/R9 random cur kept", cur_page, exp_cur);
                chk(hdr_cnt == h0, "R9 random no header", hdr_cnt - h0, 0);
            end
            if (ovw_flag) pulse_clr();
            if (($urandom % 2) == 0) begin
                tb_bnd = dec_pg(exp_cur);
                cfg_write(3, tb_bnd);
                chk(ring_empty, "R8 random empty", ring_empty, 1);
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule